// File: doc/BRIEF.md
# Floating-Point Conditional Move Unit

This block carries out one conditional register move on an eight-entry floating-point register stack. The request supplies the two opcode bytes, a lock-prefix flag and the two coprocessor control bits, emulate and task-switched. It also supplies the integer flags CF, ZF and PF, the stack top pointer, an empty tag for each physical register and the whole register file as a flat vector.

The block decodes which condition to test and works out which stack register is the source. It checks for faults. If no fault applies and the condition holds, it writes the source value into the register at the stack top. The register file is external, so the block drives a single write port. In the cycle after a request it shows the write and its fault and status pulses, and one cycle after that it gives a done strobe. The integer flags are inputs only.

Top module: `fp_cond_move`

## Requirements
- R1: A request is decoded only when the first byte is 0xDA or 0xDB and the second byte is 0xC0 or above (bits 7:6 both 1). Any other request pulses `not_handled`, with no write and no fault.
- R2: With first byte 0xDA, second-byte bits 4:3 select the condition. 0 moves if CF=1, 1 moves if ZF=1, 2 moves if CF=1 or ZF=1, and 3 moves if PF=1.
- R3: With first byte 0xDB, the same bits 4:3 select the inverse of each 0xDA condition: CF=0, ZF=0, CF=0 and ZF=0, or PF=0.
- R4: Second-byte bits 2:0 give i. The data written is physical register (top+i) mod 8, taken from `rf_in` bits [80*k+79 : 80*k]. The write target is physical register `top`.
- R5: When the condition is false, `wr_en` stays low.
- R6: A lock prefix raises `fault_ud`. This fault has the highest priority, so it masks the other two faults.
- R7: If emulate or task-switched is 1 and there is no lock prefix, `fault_nm` is raised and the underflow fault is masked.
- R8: If either physical register `top` or (top+i) mod 8 has its empty tag set, and there is no higher-priority fault, `fault_is` and `c1_clear` are raised.
- R9: Any fault suppresses the write, even when the condition is true.
- R10: The write and all fault and status pulses appear in the single cycle after the request. `done` pulses in the cycle after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| op_hi | input | 8 | First opcode byte |
| op_lo | input | 8 | Second opcode byte |
| lock_pfx | input | 1 | Lock prefix present |
| ctl_emu | input | 1 | Emulate control bit |
| ctl_ts | input | 1 | Task-switched control bit |
| flag_c | input | 1 | Carry flag |
| flag_z | input | 1 | Zero flag |
| flag_p | input | 1 | Parity flag |
| stk_top | input | 3 | Stack top pointer |
| tag_empty | input | 8 | Empty tag per physical register |
| rf_in | input | 640 | Register file, register k at bits 80k+79:80k |
| wr_en | output | 1 | Register write strobe |
| wr_idx | output | 3 | Physical register written |
| wr_data | output | 80 | Value written |
| fault_ud | output | 1 | Invalid-opcode fault pulse |
| fault_nm | output | 1 | Device-not-available fault pulse |
| fault_is | output | 1 | Stack-underflow fault pulse |
| c1_clear | output | 1 | Clear condition bit C1 |
| not_handled | output | 1 | Request was not this operation |
| done | output | 1 | Completion strobe |

## Verification
Two functions can land in the same cycle: a true move condition and a fault. The bench provokes this by setting flags that satisfy the selected condition while it also asserts the lock prefix, a control bit, or an empty tag on one of the two operands. It judges the result by checking that exactly the highest-priority fault pulses and that `wr_en` stays low. Wrapped source indices and every condition code are also driven, each with both a true and a false flag pattern.

// File: rtl/fp_cond_move.sv
module fp_cond_move #(
  parameter int W = 80,
  parameter int N = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [7:0]       op_hi,
  input  logic [7:0]       op_lo,
  input  logic             lock_pfx,
  input  logic             ctl_emu,
  input  logic             ctl_ts,
  input  logic             flag_c,
  input  logic             flag_z,
  input  logic             flag_p,
  input  logic [2:0]       stk_top,
  input  logic [N-1:0]     tag_empty,
  input  logic [N*W-1:0]   rf_in,
  output logic             wr_en,
  output logic [2:0]       wr_idx,
  output logic [W-1:0]     wr_data,
  output logic             fault_ud,
  output logic             fault_nm,
  output logic             fault_is,
  output logic             c1_clear,
  output logic             not_handled,
  output logic             done
);
  logic       hit, base, cond, ud, nm, uf, res_v;
  logic [2:0] src;

  assign hit = req_valid && (op_hi == 8'hDA || op_hi == 8'hDB) && (op_lo[7:6] == 2'b11);
  assign src = stk_top + op_lo[2:0];

  always_comb begin
    case (op_lo[4:3])
      2'd0:    base = flag_c;
      2'd1:    base = flag_z;
      2'd2:    base = flag_c | flag_z;
      default: base = flag_p;
    endcase
  end

  assign cond = base ^ op_hi[0];
  assign ud   = hit && lock_pfx;
  assign nm   = hit && !lock_pfx && (ctl_emu || ctl_ts);
  assign uf   = hit && !lock_pfx && !(ctl_emu || ctl_ts) &&
                (tag_empty[stk_top] || tag_empty[src]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_en <= 1'b0; wr_idx <= '0; wr_data <= '0;
      fault_ud <= 1'b0; fault_nm <= 1'b0; fault_is <= 1'b0;
      c1_clear <= 1'b0; not_handled <= 1'b0; res_v <= 1'b0; done <= 1'b0;
    end else begin
      wr_en       <= hit && cond && !ud && !nm && !uf;
      wr_idx      <= stk_top;
      wr_data     <= rf_in[src*W +: W];
      fault_ud    <= ud;
      fault_nm    <= nm;
      fault_is    <= uf;
      c1_clear    <= uf;
      not_handled <= req_valid && !hit;
      res_v       <= req_valid;
      done        <= res_v;
    end
  end

  assert_one_fault_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fault_ud, fault_nm, fault_is}));
  assert_fault_blocks_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_ud || fault_nm || fault_is) |-> !wr_en);
  assert_unhandled_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    not_handled |-> !(wr_en || fault_ud || fault_nm || fault_is));
  assert_dest_is_top_R4: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> wr_idx == $past(stk_top));
  assert_done_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en || fault_ud || fault_nm || fault_is || not_handled) |=> done);
  assert_c1_with_underflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    c1_clear |-> fault_is);
endmodule

// File: tb/fp_cond_move_test.sv
module fp_cond_move_test;
  logic clk = 1'b0, rst_n = 1'b0, req_valid = 1'b0;
  logic [7:0] op_hi = 8'h00, op_lo = 8'h00;
  logic lock_pfx = 0, ctl_emu = 0, ctl_ts = 0, flag_c = 0, flag_z = 0, flag_p = 0;
  logic [2:0] stk_top = 3'd0;
  logic [7:0] tag_empty = 8'h00;
  logic [639:0] rf_in;
  logic wr_en, fault_ud, fault_nm, fault_is, c1_clear, not_handled, done;
  logic [2:0] wr_idx;
  logic [79:0] wr_data;
  int errors = 0, checks = 0;

  always #10 clk = ~clk;

  fp_cond_move uut (.clk(clk), .rst_n(rst_n), .req_valid(req_valid), .op_hi(op_hi),
    .op_lo(op_lo), .lock_pfx(lock_pfx), .ctl_emu(ctl_emu), .ctl_ts(ctl_ts),
    .flag_c(flag_c), .flag_z(flag_z), .flag_p(flag_p), .stk_top(stk_top),
    .tag_empty(tag_empty), .rf_in(rf_in), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .fault_ud(fault_ud), .fault_nm(fault_nm), .fault_is(fault_is),
    .c1_clear(c1_clear), .not_handled(not_handled), .done(done));

  function automatic logic [79:0] regval(int k);
    return {16'h4000 + 16'(k), 64'hC0DE_0000_0000_0000 + 64'(k * 17)};
  endfunction

  initial for (int k = 0; k < 8; k++) rf_in[k*80 +: 80] = regval(k);

  task automatic chk(bit ok, string req, logic [79:0] act, logic [79:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // exp = {wr, ud, nm, is, nh}
  task automatic run(logic [7:0] hi, logic [7:0] lo, logic [2:0] top, logic [7:0] tags,
                     logic c, logic z, logic p, logic lk, logic em, logic ts,
                     logic [4:0] exp, string req);
    logic [4:0] act;
    @(negedge clk);
    op_hi = hi; op_lo = lo; stk_top = top; tag_empty = tags;
    flag_c = c; flag_z = z; flag_p = p; lock_pfx = lk; ctl_emu = em; ctl_ts = ts;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    act = {wr_en, fault_ud, fault_nm, fault_is, not_handled};
    chk(act == exp, req, 80'(act), 80'(exp));
    chk(c1_clear == exp[1], "R8", 80'(c1_clear), 80'(exp[1]));
    if (exp[4]) begin
      chk(wr_idx == top, "R4", 80'(wr_idx), 80'(top));
      chk(wr_data == regval(int'(3'(top + lo[2:0]))), "R4", wr_data,
          regval(int'(3'(top + lo[2:0]))));
    end
    chk(done == 1'b0, "R10", 80'(done), 80'd0);
    @(negedge clk);
    chk(done == 1'b1 && wr_en == 1'b0, "R10", 80'({done, wr_en}), 80'b10);
  endtask

  task automatic t_reset;
    chk({wr_en, fault_ud, fault_nm, fault_is, c1_clear, not_handled, done} == 7'd0,
        "R10", 80'({wr_en, done}), 80'd0);
  endtask

  task automatic t_da;
    run(8'hDA, 8'hC1, 0, 0, 1, 0, 0, 0, 0, 0, 5'b10000, "R2");
    run(8'hDA, 8'hC1, 0, 0, 0, 1, 1, 0, 0, 0, 5'b00000, "R5");
    run(8'hDA, 8'hCA, 1, 0, 0, 1, 0, 0, 0, 0, 5'b10000, "R2");
    run(8'hDA, 8'hCA, 1, 0, 1, 0, 1, 0, 0, 0, 5'b00000, "R5");
    run(8'hDA, 8'hD3, 2, 0, 0, 1, 0, 0, 0, 0, 5'b10000, "R2");
    run(8'hDA, 8'hD3, 2, 0, 0, 0, 1, 0, 0, 0, 5'b00000, "R5");
    run(8'hDA, 8'hDC, 3, 0, 0, 0, 1, 0, 0, 0, 5'b10000, "R2");
    run(8'hDA, 8'hDC, 3, 0, 1, 1, 0, 0, 0, 0, 5'b00000, "R5");
  endtask

  task automatic t_db;
    run(8'hDB, 8'hC2, 0, 0, 0, 1, 1, 0, 0, 0, 5'b10000, "R3");
    run(8'hDB, 8'hC2, 0, 0, 1, 0, 0, 0, 0, 0, 5'b00000, "R3");
    run(8'hDB, 8'hCD, 4, 0, 1, 0, 1, 0, 0, 0, 5'b10000, "R3");
    run(8'hDB, 8'hCD, 4, 0, 0, 1, 0, 0, 0, 0, 5'b00000, "R3");
    run(8'hDB, 8'hD5, 5, 0, 0, 0, 1, 0, 0, 0, 5'b10000, "R3");
    run(8'hDB, 8'hD5, 5, 0, 1, 0, 0, 0, 0, 0, 5'b00000, "R3");
    run(8'hDB, 8'hDE, 6, 0, 1, 1, 0, 0, 0, 0, 5'b10000, "R3");
    run(8'hDB, 8'hDE, 6, 0, 0, 0, 1, 0, 0, 0, 5'b00000, "R3");
  endtask

  task automatic t_wrap;
    run(8'hDA, 8'hC7, 6, 0, 1, 0, 0, 0, 0, 0, 5'b10000, "R4");
    run(8'hDB, 8'hC8, 7, 0, 0, 0, 0, 0, 0, 0, 5'b10000, "R4");
  endtask

  task automatic t_unhandled;
    run(8'hDA, 8'hBF, 0, 0, 1, 1, 1, 1, 0, 0, 5'b00001, "R1");
    run(8'hD9, 8'hC1, 0, 0, 1, 1, 1, 0, 0, 0, 5'b00001, "R1");
    run(8'hDB, 8'h41, 0, 8'hFF, 0, 0, 0, 0, 1, 0, 5'b00001, "R1");
  endtask

  task automatic t_faults;
    run(8'hDA, 8'hC1, 0, 8'h02, 1, 0, 0, 1, 1, 1, 5'b01000, "R6");
    run(8'hDA, 8'hC1, 0, 8'h02, 1, 0, 0, 0, 1, 0, 5'b00100, "R7");
    run(8'hDB, 8'hC9, 0, 8'h00, 0, 0, 0, 0, 0, 1, 5'b00100, "R7");
    run(8'hDA, 8'hC3, 6, 8'h02, 1, 0, 0, 0, 0, 0, 5'b00010, "R8");
    run(8'hDA, 8'hC3, 6, 8'h40, 1, 0, 0, 0, 0, 0, 5'b00010, "R9");
    run(8'hDA, 8'hC3, 6, 8'hBD, 1, 0, 0, 0, 0, 0, 5'b10000, "R8");
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_da(); t_db(); t_wrap(); t_unhandled(); t_faults();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule